// File: doc/BRIEF.md
# SQPN Transmit Bit Router

This block sits on the transmit side in front of a BPSK or staggered-QPSK spreader. It accepts one or two NRZ-L bit streams, each marked by a valid strobe, optionally re-codes them into a differential level format (mark or space), and steers the resulting bits onto an in-phase (I) path and a quadrature (Q) path. Steering depends on the modulation mode and on how the two paths share data. Stream A alone can feed both paths, or the two streams can feed one path each, or the bits of stream A can be dealt alternately to I and Q.

Each path keeps the most recent bit routed to it. An external rate source sets the symbol timing. A one-cycle enable at the I symbol rate releases the I bit. A one-cycle enable at twice the Q symbol rate gives the Q timing: its even pulses mark Q symbol boundaries and its odd pulses mark mid-symbol points. With the half-symbol offset enabled, Q takes its bit at the boundary and releases it at the following mid-symbol point. Each released bit comes with a one-cycle strobe. If no new bit has arrived since the last release, the path repeats its held bit.

Top module: `sqpn_tx_router`

## Requirements
- R1: Synchronous reset, active low, clears i_bit, i_stb, q_bit and q_stb. It also clears both differential levels to 0, the Q pulse phase to even, and the alternate-mode selector so that the first alternated bit goes to I.
- R2: With cfg_fmt equal to 0, or to any code from 3 to 7, a routed bit is the input bit unchanged.
- R3: With cfg_fmt = 1 (mark), a routed bit is the previous emitted bit of that stream XOR the input bit. Each stream keeps its own previous emitted bit, starting from 0.
- R4: With cfg_fmt = 2 (space), a routed bit is the previous emitted bit of that stream XOR the inverted input bit.
- R5: After a rising edge where i_sym_en is 1, i_bit shows the held I bit and i_stb is 1 for exactly one cycle. After any other edge, i_stb is 0 and i_bit is unchanged.
- R6: With cfg_sqpn = 0 (BPSK), each valid stream A bit replaces the held I bit. After every edge, q_bit and q_stb are 0, and stream B is ignored.
- R7: With cfg_sqpn = 1, cfg_alt = 0 and cfg_single = 1, each valid stream A bit replaces both the held I bit and the held Q bit.
- R8: With cfg_sqpn = 1, cfg_alt = 0 and cfg_single = 0, stream A feeds the held I bit and stream B feeds the held Q bit. The stream B differential level advances only in this mode.
- R9: With cfg_sqpn = 1 and cfg_alt = 1, valid stream A bits go alternately to I and then to Q, beginning with I after reset. cfg_single is ignored in this mode.
- R10: The Q pulse phase toggles on every q_x2_en pulse. With cfg_qdelay = 0 and cfg_sqpn = 1, an even-phase pulse puts the held Q bit on q_bit the next cycle with q_stb = 1 for one cycle.
- R11: With cfg_qdelay = 1, an even-phase pulse captures the held Q bit, and the next odd-phase pulse releases the captured bit on q_bit with a one-cycle q_stb. Apart from releases in SQPN mode, q_bit is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_sqpn | input | 1 | 0 = BPSK, 1 = SQPN |
| cfg_fmt | input | 3 | Level format: 0 NRZ-L, 1 NRZ-M, 2 NRZ-S, other codes NRZ-L |
| cfg_single | input | 1 | SQPN: 1 = stream A feeds both paths |
| cfg_alt | input | 1 | SQPN: 1 = stream A dealt alternately to I and Q |
| cfg_qdelay | input | 1 | 1 = half-symbol offset on Q |
| a_bit | input | 1 | Stream A data bit (NRZ-L) |
| a_vld | input | 1 | Stream A bit valid |
| b_bit | input | 1 | Stream B data bit (NRZ-L) |
| b_vld | input | 1 | Stream B bit valid |
| i_sym_en | input | 1 | I symbol-rate enable pulse |
| q_x2_en | input | 1 | Enable pulse at twice the Q symbol rate |
| i_bit | output | 1 | I symbol bit |
| i_stb | output | 1 | I symbol strobe |
| q_bit | output | 1 | Q symbol bit |
| q_stb | output | 1 | Q symbol strobe |

## Verification
A bit presented with its valid at edge k is held after edge k. It is released only by an enable seen at a later edge m, and it appears on the outputs after edge m. In that same cycle an enable releases the previously held bit. The Q release comes one cycle after an even q_x2_en pulse, or one cycle after the following odd pulse when the offset is enabled. The bench drives inputs and samples outputs at the falling edge. For each rising edge it advances a per-cycle model written from the requirements, so that every comparison falls on the cycle in which the registered outputs are due. Directed sequences with fixed expected bits cover the mark, space and alternating cases.

// File: rtl/sqpn_pkg.sv
// Shared types for the SQPN transmit bit router.
package sqpn_pkg;

    // Width of the level-format selector.
    localparam int FMT_W = 3;

    // Format codes with a defined conversion; every other code is pass-through.
    localparam logic [FMT_W-1:0] FMT_MARK  = FMT_W'(1);
    localparam logic [FMT_W-1:0] FMT_SPACE = FMT_W'(2);

    // How input streams are steered onto the I and Q paths.
    typedef enum logic [1:0] {
        ROUTE_BPSK   = 2'd0,
        ROUTE_SINGLE = 2'd1,
        ROUTE_DUAL   = 2'd2,
        ROUTE_ALT    = 2'd3
    } route_e;

    // Number of input streams.
    localparam int N_STREAMS = 2;

endpackage

// File: rtl/sqpn_nrz_conv.sv
// Level-format converter for one stream.
// Does: emits the NRZ-L input unchanged, or re-codes it as mark (toggle on 1)
//       or space (toggle on 0) relative to the last bit it emitted.
// Assumes: the emitted bit is combinational and is consumed in the same cycle as in_vld;
//          the level register holds the last emitted bit and starts at 0.
module sqpn_nrz_conv
    import sqpn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FMT_W-1:0] fmt,
    input  logic             in_bit,
    input  logic             in_vld,
    output logic             out_bit
);

    logic level_q;

    // Compute the bit this input produces under the selected format.
    always_comb begin
        case (fmt)
            FMT_MARK:  out_bit = level_q ^ in_bit;
            FMT_SPACE: out_bit = level_q ^ ~in_bit;
            default:   out_bit = in_bit;
        endcase
    end

    // Remember the last emitted bit as the reference level.
    always_ff @(posedge clk) begin
        if (!rst_n)      level_q <= 1'b0;
        else if (in_vld) level_q <= out_bit;
    end

endmodule

// File: rtl/sqpn_path_router.sv
// Path router.
// Does: steers converted stream bits into the held I and held Q bits
//       according to the routing mode.
// Assumes: a_bit/b_bit are already converted; the alternate selector
//          survives mode changes and is cleared only by reset.
module sqpn_path_router
    import sqpn_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  route_e route,
    input  logic   a_bit,
    input  logic   a_vld,
    input  logic   b_bit,
    input  logic   b_vld,
    output logic   i_hold,
    output logic   q_hold
);

    logic alt_to_q;

    // Update the held bits from the streams that feed them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_hold   <= 1'b0;
            q_hold   <= 1'b0;
            alt_to_q <= 1'b0;
        end else begin
            case (route)
                ROUTE_BPSK: begin
                    if (a_vld) i_hold <= a_bit;
                end
                ROUTE_SINGLE: begin
                    if (a_vld) begin
                        i_hold <= a_bit;
                        q_hold <= a_bit;
                    end
                end
                ROUTE_DUAL: begin
                    if (a_vld) i_hold <= a_bit;
                    if (b_vld) q_hold <= b_bit;
                end
                default: begin
                    if (a_vld) begin
                        if (alt_to_q) q_hold <= a_bit;
                        else          i_hold <= a_bit;
                        alt_to_q <= ~alt_to_q;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/sqpn_q_timer.sv
// Q symbol timer.
// Does: splits the double-rate pulse into symbol-boundary (even) and
//       mid-symbol (odd) points, and releases the Q bit at the boundary,
//       or half a symbol later when the offset is enabled.
// Assumes: q_x2_en arrives at exactly twice the Q symbol rate; in BPSK the
//          outputs are forced to zero while the phase keeps counting.
module sqpn_q_timer (
    input  logic clk,
    input  logic rst_n,
    input  logic sqpn,
    input  logic qdelay,
    input  logic x2_en,
    input  logic q_hold,
    output logic q_bit,
    output logic q_stb
);

    logic odd_q;
    logic dly_q;
    logic even_pulse;
    logic odd_pulse;

    // Classify the current double-rate pulse by phase.
    always_comb begin
        even_pulse = x2_en & ~odd_q;
        odd_pulse  = x2_en &  odd_q;
    end

    // Track the pulse phase and capture the bit for the delayed release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_q <= 1'b0;
            dly_q <= 1'b0;
        end else begin
            if (x2_en) odd_q <= ~odd_q;
            if (even_pulse && qdelay) dly_q <= q_hold;
        end
    end

    // Drive the Q symbol bit and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_bit <= 1'b0;
            q_stb <= 1'b0;
        end else if (!sqpn) begin
            q_bit <= 1'b0;
            q_stb <= 1'b0;
        end else if (even_pulse && !qdelay) begin
            q_bit <= q_hold;
            q_stb <= 1'b1;
        end else if (odd_pulse && qdelay) begin
            q_bit <= dly_q;
            q_stb <= 1'b1;
        end else begin
            q_stb <= 1'b0;
        end
    end

endmodule

// File: rtl/sqpn_tx_router.sv
// SQPN transmit bit router, top level.
// Does: converts the input streams to the configured level format, routes
//       them to the I/Q paths and times the symbol outputs.
// Assumes: configuration is quasi-static; the rate enables are one-cycle pulses.
module sqpn_tx_router
    import sqpn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sqpn,
    input  logic [FMT_W-1:0] cfg_fmt,
    input  logic             cfg_single,
    input  logic             cfg_alt,
    input  logic             cfg_qdelay,
    input  logic             a_bit,
    input  logic             a_vld,
    input  logic             b_bit,
    input  logic             b_vld,
    input  logic             i_sym_en,
    input  logic             q_x2_en,
    output logic             i_bit,
    output logic             i_stb,
    output logic             q_bit,
    output logic             q_stb
);

    route_e               route;
    logic [N_STREAMS-1:0] s_bit;
    logic [N_STREAMS-1:0] s_vld;
    logic [N_STREAMS-1:0] s_conv;
    logic                 i_hold;
    logic                 q_hold;

    // Decode the routing mode; alternation takes precedence over single source.
    always_comb begin
        if (!cfg_sqpn)       route = ROUTE_BPSK;
        else if (cfg_alt)    route = ROUTE_ALT;
        else if (cfg_single) route = ROUTE_SINGLE;
        else                 route = ROUTE_DUAL;
    end

    // Gather the streams; stream B advances only when it feeds Q.
    always_comb begin
        s_bit = {b_bit, a_bit};
        s_vld = {b_vld & (route == ROUTE_DUAL), a_vld};
    end

    // One converter per input stream.
    generate
        for (genvar s = 0; s < N_STREAMS; s++) begin : g_conv
            sqpn_nrz_conv u_conv (
                .clk     (clk),
                .rst_n   (rst_n),
                .fmt     (cfg_fmt),
                .in_bit  (s_bit[s]),
                .in_vld  (s_vld[s]),
                .out_bit (s_conv[s])
            );
        end
    endgenerate

    sqpn_path_router u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .route  (route),
        .a_bit  (s_conv[0]),
        .a_vld  (s_vld[0]),
        .b_bit  (s_conv[1]),
        .b_vld  (s_vld[1]),
        .i_hold (i_hold),
        .q_hold (q_hold)
    );

    // Release the held I bit on each I symbol enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_bit <= 1'b0;
            i_stb <= 1'b0;
        end else begin
            i_stb <= i_sym_en;
            if (i_sym_en) i_bit <= i_hold;
        end
    end

    sqpn_q_timer u_qtim (
        .clk    (clk),
        .rst_n  (rst_n),
        .sqpn   (cfg_sqpn),
        .qdelay (cfg_qdelay),
        .x2_en  (q_x2_en),
        .q_hold (q_hold),
        .q_bit  (q_bit),
        .q_stb  (q_stb)
    );

endmodule

// File: rtl/sqpn_tx_router_chk.sv
// Property checker for the SQPN transmit bit router, bound to the top level.
module sqpn_tx_router_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_sqpn,
    input logic i_sym_en,
    input logic q_x2_en,
    input logic i_bit,
    input logic i_stb,
    input logic q_bit,
    input logic q_stb
);

    // R5: an I enable yields a strobe on the next cycle
    p_i_stb_follows_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        i_sym_en |=> i_stb);

    // R5: without an I enable the I bit holds
    p_i_bit_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !i_sym_en |=> $stable(i_bit));

    // R6: BPSK keeps the Q outputs quiet
    p_bpsk_q_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sqpn |=> (!q_stb && !q_bit));

    // R10: a Q strobe only follows a double-rate pulse
    p_q_stb_needs_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q_stb |-> $past(q_x2_en));

    // R11: in SQPN, without a pulse the Q bit holds
    p_q_bit_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_x2_en && cfg_sqpn) |=> $stable(q_bit));

endmodule

bind sqpn_tx_router sqpn_tx_router_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_sqpn (cfg_sqpn),
    .i_sym_en (i_sym_en),
    .q_x2_en  (q_x2_en),
    .i_bit    (i_bit),
    .i_stb    (i_stb),
    .q_bit    (q_bit),
    .q_stb    (q_stb)
);

// File: tb/sqpn_tx_router_tb.sv
// Bench for the SQPN transmit bit router: seeded random segments plus directed cases.
module sqpn_tx_router_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sqpn = 1'b0, cfg_single = 1'b0, cfg_alt = 1'b0, cfg_qdelay = 1'b0;
    logic [2:0] cfg_fmt = 3'd0;
    logic       a_bit = 1'b0, a_vld = 1'b0, b_bit = 1'b0, b_vld = 1'b0;
    logic       i_sym_en = 1'b0, q_x2_en = 1'b0;
    logic       i_bit, i_stb, q_bit, q_stb;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference model state
    logic m_la, m_lb, m_ih, m_qh, m_sel, m_ph, m_qd;
    logic m_ib, m_is, m_qb, m_qs;

    always #4 clk = ~clk;

    sqpn_tx_router dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_sqpn(cfg_sqpn), .cfg_fmt(cfg_fmt),
        .cfg_single(cfg_single), .cfg_alt(cfg_alt), .cfg_qdelay(cfg_qdelay),
        .a_bit(a_bit), .a_vld(a_vld), .b_bit(b_bit), .b_vld(b_vld),
        .i_sym_en(i_sym_en), .q_x2_en(q_x2_en),
        .i_bit(i_bit), .i_stb(i_stb), .q_bit(q_bit), .q_stb(q_stb)
    );

    function automatic logic conv(input logic [2:0] f, input logic lvl, input logic b);
        if (f == 3'd1)      return lvl ^ b;
        else if (f == 3'd2) return lvl ^ ~b;
        else                return b;
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        {m_la, m_lb, m_ih, m_qh, m_sel, m_ph, m_qd} = '0;
        {m_ib, m_is, m_qb, m_qs} = '0;
    endtask

    // Advance the model by one rising edge using the inputs now applied.
    task automatic model_step();
        logic ca, cb;
        ca = conv(cfg_fmt, m_la, a_bit);
        cb = conv(cfg_fmt, m_lb, b_bit);
        m_is = i_sym_en;
        if (i_sym_en) m_ib = m_ih;
        if (!cfg_sqpn) begin
            m_qb = 1'b0; m_qs = 1'b0;
        end else begin
            m_qs = 1'b0;
            if (q_x2_en && !m_ph && !cfg_qdelay) begin m_qb = m_qh; m_qs = 1'b1; end
            if (q_x2_en &&  m_ph &&  cfg_qdelay) begin m_qb = m_qd; m_qs = 1'b1; end
        end
        if (q_x2_en && !m_ph && cfg_qdelay) m_qd = m_qh;
        if (q_x2_en) m_ph = ~m_ph;
        if (a_vld) m_la = ca;
        if (!cfg_sqpn) begin
            if (a_vld) m_ih = ca;
        end else if (cfg_alt) begin
            if (a_vld) begin
                if (m_sel) m_qh = ca; else m_ih = ca;
                m_sel = ~m_sel;
            end
        end else if (cfg_single) begin
            if (a_vld) begin m_ih = ca; m_qh = ca; end
        end else begin
            if (a_vld) m_ih = ca;
            if (b_vld) begin m_qh = cb; m_lb = cb; end
        end
    endtask

    function automatic string fmt_tag();
        if (cfg_fmt == 3'd1)      return "R3";
        else if (cfg_fmt == 3'd2) return "R4";
        else                      return "R2";
    endfunction

    function automatic string q_tag();
        if (!cfg_sqpn)       return "R6";
        else if (cfg_qdelay) return "R11";
        else if (cfg_alt)    return "R9";
        else if (cfg_single) return "R7";
        else                 return "R8";
    endfunction

    // One cycle: inputs are set at a falling edge, compared at the next falling edge.
    task automatic cyc(input logic ab, input logic av, input logic bb, input logic bv,
                       input logic ie, input logic q2);
        a_bit = ab; a_vld = av; b_bit = bb; b_vld = bv; i_sym_en = ie; q_x2_en = q2;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check("R5", "i_stb", i_stb, m_is);
        check(fmt_tag(), "i_bit", i_bit, m_ib);
        check(cfg_qdelay ? "R11" : "R10", "q_stb", q_stb, m_qs);
        check(q_tag(), "q_bit", q_bit, m_qb);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        a_vld = 1'b0; b_vld = 1'b0; i_sym_en = 1'b0; q_x2_en = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check("R1", "i_bit", i_bit, 1'b0);
        check("R1", "i_stb", i_stb, 1'b0);
        check("R1", "q_bit", q_bit, 1'b0);
        check("R1", "q_stb", q_stb, 1'b0);
    endtask

    task automatic set_cfg(input logic sq, input logic [2:0] f, input logic si,
                           input logic al, input logic qd);
        cfg_sqpn = sq; cfg_fmt = f; cfg_single = si; cfg_alt = al; cfg_qdelay = qd;
    endtask

    task automatic rand_seg(input int n);
        for (int k = 0; k < n; k++) begin
            cyc($urandom_range(0, 1), ($urandom_range(0, 3) == 0),
                $urandom_range(0, 1), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 7) == 0), ($urandom_range(0, 3) == 0));
        end
    endtask

    initial begin : main
        logic [3:0] exp_m;
        process::self().srandom(32'h5A17);
        @(negedge clk);
        do_reset();

        // R3: mark coding in BPSK, inputs 1,0,1,1 from level 0 give 1,1,0,1
        set_cfg(1'b0, 3'd1, 1'b0, 1'b0, 1'b0);
        exp_m = 4'b1011; // bit k of the expected sequence, LSB first
        for (int k = 0; k < 4; k++) begin
            cyc((k != 1), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
            cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            check("R3", "mark directed", i_bit, exp_m[k]);
        end

        // R4: space coding, inputs 0,1,0 from level 0 give 1,1,0
        do_reset();
        set_cfg(1'b0, 3'd2, 1'b0, 1'b0, 1'b0);
        exp_m = 4'b0011;
        for (int k = 0; k < 3; k++) begin
            cyc((k == 1), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
            cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            check("R4", "space directed", i_bit, exp_m[k]);
        end

        // R9: alternation starts on I after reset (format code 5 acts as NRZ-L, R2)
        do_reset();
        set_cfg(1'b1, 3'd5, 1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R9", "alt first bit on I", i_bit, 1'b1);
        check("R9", "alt second bit on Q", q_bit, 1'b0);
        check("R10", "Q strobe on even pulse", q_stb, 1'b1);

        // R11: captured at even pulse, released only at odd pulse
        set_cfg(1'b1, 3'd0, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); // odd pulse, realigns phase
        cfg_qdelay = 1'b1;
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R11", "no strobe at boundary", q_stb, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R11", "mid-symbol release", q_stb, 1'b1);
        check("R11", "released bit", q_bit, 1'b1);

        // Random segments over all modes and formats
        for (int s = 0; s < 16; s++) begin
            set_cfg((s % 4) != 0, 3'(s % 6), s[2], s[3], s[0]);
            rand_seg(250);
        end
        do_reset();
        for (int s = 0; s < 8; s++) begin
            set_cfg($urandom_range(0, 1), 3'($urandom_range(0, 7)), $urandom_range(0, 1),
                    $urandom_range(0, 1), $urandom_range(0, 1));
            rand_seg(250);
        end

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog expired, actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule